// File: doc/BRIEF.md
# CPU Interrupt Delivery Controller

This block sits between the interrupt sources of a system and one processor core. It captures three kinds of request. A reset request and a non-maskable request are single-cycle event strobes. A maskable request is a level event that carries a 6-bit value. Each captured request stays pending until the block serves it. Requests are served only on cycles where the core marks an instruction boundary.

On such a cycle the block takes the highest-priority pending request. A reset or non-maskable request produces a one-cycle strobe on a shared output. A maskable level is copied into the hardware-interrupt pending field that the block owns. It also produces a one-cycle interrupt strobe if the core's status register allows it: the current-interrupt-enable bit must be set and the level must overlap the status mask. A level that is not allowed stays pending and is tried again at every later boundary.

A level event whose value is zero withdraws the interrupt. At the next evaluation the pending field is cleared and nothing is signalled. The core feeds in its enable bit and mask. It takes the two strobes as exception requests and reads the pending field as the interrupt bits of its cause register.

Top module: `irq_delivery_ctrl`

## Requirements
- R1: At an evaluation only one request is served. The order is reset first, then non-maskable, then end-of-interrupt or maskable level. Lower-priority requests stay pending for later boundaries.
- R2: A pending reset request or a pending non-maskable request, when served, drives `nmi_rst_exc_o` high for exactly one cycle. The served flag is cleared, so the next boundary produces no second strobe from it.
- R3: A level event with value 0 withdraws any pending level. At the next evaluation that reaches it, `cause_ip_o` becomes 0, `int_exc_o` stays low, and later unmasking delivers nothing.
- R4: When a nonzero pending level is evaluated, `cause_ip_o` is loaded with that 6-bit level in the same clock edge.
- R5: `int_exc_o` pulses for one cycle only when `sr_ie_i` is 1 and (level AND `sr_mask_i`) is nonzero. A taken level is no longer pending afterwards.
- R6: A level that is blocked by the enable bit or the mask stays pending. It is re-evaluated at every following boundary and is delivered at the first boundary where the status allows it.
- R7: A later level event replaces an earlier pending level value. The bits of the two values are not merged.
- R8: Evaluation happens only on a clock edge where `insn_boundary_i` is 1. The strobes and `cause_ip_o` change on that edge and do not change on edges without a boundary.
- R9: A synchronous active-high `rst` clears all pending requests, the withdrawal marker, both strobes and `cause_ip_o`.
- R10: An event that arrives on the same edge as an evaluation is kept for the next evaluation. A new event wins over the clearing of the flag or level that is being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req_i | input | 1 | Reset request event strobe |
| nmi_req_i | input | 1 | Non-maskable request event strobe |
| lvl_evt_i | input | 1 | Maskable level event strobe |
| lvl_val_i | input | 6 | Level carried by the event; 0 means withdrawal |
| insn_boundary_i | input | 1 | Core is between instructions; evaluation allowed |
| sr_ie_i | input | 1 | Current-interrupt-enable bit of the status register |
| sr_mask_i | input | 6 | Interrupt mask field of the status register |
| nmi_rst_exc_o | output | 1 | One-cycle strobe for a reset or non-maskable exception |
| int_exc_o | output | 1 | One-cycle strobe for a maskable interrupt exception |
| cause_ip_o | output | 6 | Hardware-interrupt pending field of the cause register |

## Verification
The assertions check these properties on every cycle:
- The two strobes are never high together.
- Every strobe follows a boundary and has a pending request behind it.
- An interrupt strobe always has the enable bit and an overlap between mask and cause behind it.
- Edges without a boundary leave all outputs quiet.
- A blocked level is kept and shown in the cause field.
- A withdrawal clears the field.

Some behaviour spans several boundaries, and only the bench's scenarios show it:
- the full priority sequence of reset, then non-maskable, then level;
- a level delivered only after a later change of the mask;
- overwriting of one level by another;
- events that coincide with their own service.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int IRQ_W = 6;

  typedef enum logic [2:0] {
    SRV_NONE,
    SRV_RST,
    SRV_NMI,
    SRV_EOI,
    SRV_LVL
  } srv_e;
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int IP_W = irq_pkg::IRQ_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rst_evt,
  input  logic            nmi_evt,
  input  logic            lvl_evt,
  input  logic [IP_W-1:0] lvl_val,
  input  logic            clr_rst,
  input  logic            clr_nmi,
  input  logic            clr_eoi,
  input  logic            clr_lvl,
  output logic            pend_rst,
  output logic            pend_nmi,
  output logic            pend_eoi,
  output logic [IP_W-1:0] pend_lvl
);
  localparam logic [IP_W-1:0] LVL_ZERO = '0;

  // Clears come first; a same-edge event overrides them (later NBA wins).
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_rst <= 1'b0;
      pend_nmi <= 1'b0;
      pend_eoi <= 1'b0;
      pend_lvl <= LVL_ZERO;
    end else begin
      if (clr_rst) pend_rst <= 1'b0;
      if (clr_nmi) pend_nmi <= 1'b0;
      if (clr_eoi) pend_eoi <= 1'b0;
      if (clr_lvl) pend_lvl <= LVL_ZERO;
      if (rst_evt) pend_rst <= 1'b1;
      if (nmi_evt) pend_nmi <= 1'b1;
      if (lvl_evt) begin
        if (lvl_val == LVL_ZERO) begin
          pend_eoi <= 1'b1;
          pend_lvl <= LVL_ZERO;
        end else begin
          pend_eoi <= 1'b0;
          pend_lvl <= lvl_val;
        end
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int IP_W = irq_pkg::IRQ_W
) (
  input  logic            eval_en,
  input  logic            pend_rst,
  input  logic            pend_nmi,
  input  logic            pend_eoi,
  input  logic [IP_W-1:0] pend_lvl,
  input  logic            sr_ie,
  input  logic [IP_W-1:0] sr_mask,
  output irq_pkg::srv_e   srv,
  output logic            lvl_take,
  output logic            clr_rst,
  output logic            clr_nmi,
  output logic            clr_eoi,
  output logic            clr_lvl
);
  import irq_pkg::*;

  function automatic logic lvl_allowed(input logic ie,
                                       input logic [IP_W-1:0] mask,
                                       input logic [IP_W-1:0] lvl);
    return ie && ((lvl & mask) != '0);
  endfunction

  always_comb begin
    srv = SRV_NONE;
    if (eval_en) begin
      if (pend_rst)            srv = SRV_RST;
      else if (pend_nmi)       srv = SRV_NMI;
      else if (pend_eoi)       srv = SRV_EOI;
      else if (pend_lvl != '0) srv = SRV_LVL;
    end
  end

  assign lvl_take = (srv == SRV_LVL) && lvl_allowed(sr_ie, sr_mask, pend_lvl);
  assign clr_rst  = (srv == SRV_RST);
  assign clr_nmi  = (srv == SRV_NMI);
  assign clr_eoi  = (srv == SRV_EOI);
  assign clr_lvl  = lvl_take;
endmodule

// File: rtl/irq_out_regs.sv
module irq_out_regs #(
  parameter int IP_W = irq_pkg::IRQ_W
) (
  input  logic            clk,
  input  logic            rst,
  input  irq_pkg::srv_e   srv,
  input  logic            lvl_take,
  input  logic [IP_W-1:0] pend_lvl,
  output logic            nmi_rst_exc,
  output logic            int_exc,
  output logic [IP_W-1:0] cause_ip
);
  import irq_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_rst_exc <= 1'b0;
      int_exc     <= 1'b0;
      cause_ip    <= '0;
    end else begin
      nmi_rst_exc <= (srv == SRV_RST) || (srv == SRV_NMI);
      int_exc     <= lvl_take;
      if (srv == SRV_EOI)      cause_ip <= '0;
      else if (srv == SRV_LVL) cause_ip <= pend_lvl;
    end
  end
endmodule

// File: rtl/irq_delivery_ctrl.sv
module irq_delivery_ctrl #(
  parameter int IP_W = irq_pkg::IRQ_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rst_req_i,
  input  logic            nmi_req_i,
  input  logic            lvl_evt_i,
  input  logic [IP_W-1:0] lvl_val_i,
  input  logic            insn_boundary_i,
  input  logic            sr_ie_i,
  input  logic [IP_W-1:0] sr_mask_i,
  output logic            nmi_rst_exc_o,
  output logic            int_exc_o,
  output logic [IP_W-1:0] cause_ip_o
);
  import irq_pkg::*;

  logic            pend_rst_q, pend_nmi_q, pend_eoi_q;
  logic [IP_W-1:0] pend_lvl_q;
  srv_e            srv_sel;
  logic            lvl_take;
  logic            clr_rst, clr_nmi, clr_eoi, clr_lvl;

  irq_pend_latch #(.IP_W(IP_W)) i_pend (
    .clk(clk), .rst(rst),
    .rst_evt(rst_req_i), .nmi_evt(nmi_req_i),
    .lvl_evt(lvl_evt_i), .lvl_val(lvl_val_i),
    .clr_rst(clr_rst), .clr_nmi(clr_nmi), .clr_eoi(clr_eoi), .clr_lvl(clr_lvl),
    .pend_rst(pend_rst_q), .pend_nmi(pend_nmi_q),
    .pend_eoi(pend_eoi_q), .pend_lvl(pend_lvl_q)
  );

  irq_arbiter #(.IP_W(IP_W)) i_arb (
    .eval_en(insn_boundary_i),
    .pend_rst(pend_rst_q), .pend_nmi(pend_nmi_q),
    .pend_eoi(pend_eoi_q), .pend_lvl(pend_lvl_q),
    .sr_ie(sr_ie_i), .sr_mask(sr_mask_i),
    .srv(srv_sel), .lvl_take(lvl_take),
    .clr_rst(clr_rst), .clr_nmi(clr_nmi), .clr_eoi(clr_eoi), .clr_lvl(clr_lvl)
  );

  irq_out_regs #(.IP_W(IP_W)) i_out (
    .clk(clk), .rst(rst),
    .srv(srv_sel), .lvl_take(lvl_take), .pend_lvl(pend_lvl_q),
    .nmi_rst_exc(nmi_rst_exc_o), .int_exc(int_exc_o), .cause_ip(cause_ip_o)
  );
endmodule

// File: rtl/irq_delivery_chk.sv
module irq_delivery_chk #(
  parameter int IP_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            lvl_evt_i,
  input logic            insn_boundary_i,
  input logic            sr_ie_i,
  input logic [IP_W-1:0] sr_mask_i,
  input logic            nmi_rst_exc_o,
  input logic            int_exc_o,
  input logic [IP_W-1:0] cause_ip_o,
  input logic            pend_rst_q,
  input logic            pend_nmi_q,
  input logic            pend_eoi_q,
  input logic [IP_W-1:0] pend_lvl_q
);
  logic only_lvl;
  assign only_lvl = insn_boundary_i && !pend_rst_q && !pend_nmi_q && !pend_eoi_q
                    && (pend_lvl_q != '0);

  AST_EXC_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(nmi_rst_exc_o && int_exc_o)); // R1

  AST_RST_KEEPS_NMI: assert property (@(posedge clk) disable iff (rst)
    (insn_boundary_i && pend_rst_q && pend_nmi_q) |=> pend_nmi_q); // R1

  AST_NR_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    nmi_rst_exc_o |-> ($past(insn_boundary_i) && $past(pend_rst_q || pend_nmi_q))); // R2

  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (insn_boundary_i && !pend_rst_q && !pend_nmi_q && pend_eoi_q)
      |=> (cause_ip_o == '0 && !int_exc_o)); // R3

  AST_CAUSE_LOAD: assert property (@(posedge clk) disable iff (rst)
    only_lvl |=> (cause_ip_o == $past(pend_lvl_q))); // R4

  AST_INT_GATED: assert property (@(posedge clk) disable iff (rst)
    int_exc_o |-> ($past(sr_ie_i) && (($past(sr_mask_i) & cause_ip_o) != '0))); // R5

  AST_BLOCKED_KEPT: assert property (@(posedge clk) disable iff (rst)
    (only_lvl && !lvl_evt_i && !(sr_ie_i && ((pend_lvl_q & sr_mask_i) != '0)))
      |=> (!int_exc_o && pend_lvl_q == $past(pend_lvl_q))); // R6

  AST_QUIET_NO_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !insn_boundary_i |=> (!nmi_rst_exc_o && !int_exc_o && $stable(cause_ip_o))); // R8

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (cause_ip_o == '0 && !nmi_rst_exc_o && !int_exc_o && !pend_rst_q
             && !pend_nmi_q && !pend_eoi_q && pend_lvl_q == '0)); // R9
endmodule

bind irq_delivery_ctrl irq_delivery_chk #(.IP_W(IP_W)) i_chk (
  .clk(clk), .rst(rst), .lvl_evt_i(lvl_evt_i), .insn_boundary_i(insn_boundary_i),
  .sr_ie_i(sr_ie_i), .sr_mask_i(sr_mask_i),
  .nmi_rst_exc_o(nmi_rst_exc_o), .int_exc_o(int_exc_o), .cause_ip_o(cause_ip_o),
  .pend_rst_q(pend_rst_q), .pend_nmi_q(pend_nmi_q),
  .pend_eoi_q(pend_eoi_q), .pend_lvl_q(pend_lvl_q)
);

// File: tb/test_irq_delivery_ctrl.sv
module test_irq_delivery_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_req_i = 0, nmi_req_i = 0, lvl_evt_i = 0, insn_boundary_i = 0, sr_ie_i = 0;
  logic [5:0] lvl_val_i = 0, sr_mask_i = 0;
  logic nmi_rst_exc_o, int_exc_o;
  logic [5:0] cause_ip_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_delivery_ctrl i_irq_delivery_ctrl (
    .clk(clk), .rst(rst), .rst_req_i(rst_req_i), .nmi_req_i(nmi_req_i),
    .lvl_evt_i(lvl_evt_i), .lvl_val_i(lvl_val_i), .insn_boundary_i(insn_boundary_i),
    .sr_ie_i(sr_ie_i), .sr_mask_i(sr_mask_i), .nmi_rst_exc_o(nmi_rst_exc_o),
    .int_exc_o(int_exc_o), .cause_ip_o(cause_ip_o)
  );

  // Behavioural reference: integers for pending state, evaluated per edge.
  int m_rst = 0, m_nmi = 0, m_eoi = 0, m_lvl = 0;
  int e_nr = 0, e_int = 0, e_cause = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_rst = 0; m_nmi = 0; m_eoi = 0; m_lvl = 0;
      e_nr = 0; e_int = 0; e_cause = 0;
    end else begin
      e_nr = 0; e_int = 0;
      if (insn_boundary_i) begin
        if (m_rst != 0) begin m_rst = 0; e_nr = 1; end
        else if (m_nmi != 0) begin m_nmi = 0; e_nr = 1; end
        else if (m_eoi != 0) begin m_eoi = 0; e_cause = 0; end
        else if (m_lvl != 0) begin
          e_cause = m_lvl;
          if (sr_ie_i && ((m_lvl & int'(sr_mask_i)) != 0)) begin
            e_int = 1; m_lvl = 0;
          end
        end
      end
      if (rst_req_i) m_rst = 1;
      if (nmi_req_i) m_nmi = 1;
      if (lvl_evt_i) begin
        if (lvl_val_i == 0) begin m_eoi = 1; m_lvl = 0; end
        else begin m_lvl = int'(lvl_val_i); m_eoi = 0; end
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      chk(int'(nmi_rst_exc_o), e_nr, "R2 model nmi_rst_exc");
      chk(int'(int_exc_o), e_int, "R5 model int_exc");
      chk(int'(cause_ip_o), e_cause, "R4 model cause");
    end
  end

  task automatic cyc(input bit r, input bit n, input bit le, input int lv, input bit b);
    rst_req_i = r; nmi_req_i = n; lvl_evt_i = le; lvl_val_i = 6'(lv); insn_boundary_i = b;
    @(negedge clk);
  endtask

  task automatic outs(input int nr, input int it, input int cs, input string tag);
    chk(int'(nmi_rst_exc_o), nr, {tag, " nmi_rst"});
    chk(int'(int_exc_o), it, {tag, " int"});
    chk(int'(cause_ip_o), cs, {tag, " cause"});
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    outs(0, 0, 0, "R9 reset state");
    rst = 0;

    // R4/R5: enabled level delivered, then no longer pending
    sr_ie_i = 1; sr_mask_i = 6'h3f;
    cyc(0,0,1,5,0); outs(0,0,0,"R8 event without boundary");
    cyc(0,0,0,0,1); outs(0,1,5,"R5 taken level");
    cyc(0,0,0,0,1); outs(0,0,5,"R5 taken level cleared");

    // R6: blocked, retried, delivered after unmask
    sr_mask_i = 6'b000100;
    cyc(0,0,1,3,0);
    cyc(0,0,0,0,1); outs(0,0,3,"R6 blocked");
    for (int i = 0; i < 3; i++) begin
      cyc(0,0,0,0,1); outs(0,0,3,"R6 retry blocked");
    end
    sr_mask_i = 6'b000001;
    cyc(0,0,0,0,1); outs(0,1,3,"R6 delivered after unmask");

    // R3: withdrawal
    sr_mask_i = 0;
    cyc(0,0,1,2,0);
    cyc(0,0,0,0,1); outs(0,0,2,"R3 pending before withdraw");
    cyc(0,0,1,0,0);
    cyc(0,0,0,0,1); outs(0,0,0,"R3 withdraw clears cause");
    sr_mask_i = 6'h3f;
    cyc(0,0,0,0,1); outs(0,0,0,"R3 nothing after unmask");

    // R1: priority reset > nmi > level
    cyc(1,1,1,7,0);
    cyc(0,0,0,0,1); outs(1,0,0,"R1 reset first");
    cyc(0,0,0,0,1); outs(1,0,0,"R1 nmi second");
    cyc(0,0,0,0,1); outs(0,1,7,"R1 level third");
    cyc(0,0,0,0,1); outs(0,0,7,"R2 nothing left");

    // R8: no evaluation without boundary
    cyc(0,1,0,0,0);
    for (int i = 0; i < 3; i++) begin
      cyc(0,0,0,0,0); outs(0,0,7,"R8 no boundary");
    end
    cyc(0,0,0,0,1); outs(1,0,7,"R8 served at boundary");
    cyc(0,0,0,0,1); outs(0,0,7,"R2 single pulse");

    // R7: overwrite
    sr_mask_i = 6'b000001;
    cyc(0,0,1,1,0);
    cyc(0,0,1,4,0);
    cyc(0,0,0,0,1); outs(0,0,4,"R7 later level replaces");
    cyc(0,0,1,0,0);
    cyc(0,0,0,0,1); outs(0,0,0,"R3 cleanup");

    // R5: enable bit off
    sr_ie_i = 0; sr_mask_i = 6'h3f;
    cyc(0,0,1,9,0);
    cyc(0,0,0,0,1); outs(0,0,9,"R5 ie off blocks");
    sr_ie_i = 1;
    cyc(0,0,0,0,1); outs(0,1,9,"R5 ie on delivers");

    // R10: events coinciding with evaluation
    sr_mask_i = 0;
    cyc(0,0,1,6,0);
    cyc(0,0,0,0,1); outs(0,0,6,"R10 setup");
    cyc(0,1,1,10,1); outs(0,0,6,"R10 old level evaluated");
    cyc(0,0,0,0,1); outs(1,0,6,"R10 new nmi kept");
    sr_mask_i = 6'h3f;
    cyc(0,0,0,0,1); outs(0,1,10,"R10 new level kept");
    cyc(0,1,0,0,0);
    cyc(0,1,0,0,1); outs(1,0,10,"R10 nmi served");
    cyc(0,0,0,0,1); outs(1,0,10,"R10 same-edge nmi kept");
    cyc(0,0,0,0,1); outs(0,0,10,"R10 drained");

    // R9: reset mid-run
    sr_mask_i = 0;
    cyc(0,0,1,5,0);
    cyc(1,1,0,0,1); outs(0,0,5,"R9 before reset");
    rst = 1;
    cyc(0,0,0,0,0); outs(0,0,0,"R9 reset clears outputs");
    rst = 0; sr_mask_i = 6'h3f;
    cyc(0,0,0,0,1); outs(0,0,0,"R9 pending cleared");

    // Random phase, checked by the model every cycle
    for (int i = 0; i < 600; i++) begin
      sr_ie_i = 1'($urandom_range(0, 3) != 0);
      sr_mask_i = 6'($urandom);
      cyc(1'($urandom_range(0, 15) == 0), 1'($urandom_range(0, 11) == 0),
          1'($urandom_range(0, 3) == 0), $urandom_range(0, 63),
          1'($urandom_range(0, 2) != 0));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule